// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the processor-side controller that decides, once an instruction has finished executing, whether to enter an interrupt handler or to fetch the next instruction. It holds the program counter, the stack pointer and the global interrupt enable flag. An interrupt is taken only when the enable flag and the pending-status input are both high at the instruction-end strobe.

When an interrupt is taken, the sequencer runs a fixed chain of one-clock micro-steps, in this order:
1. Lower the stack pointer by one.
2. Write the current program counter to memory at that new stack address. The program counter already holds the address of the following instruction, so the handler can resume there.
3. Raise the acknowledge output for one clock, and load the program counter from the device-supplied vector.
4. Clear the enable flag.
5. Return to fetch.

While the block is executing, the surrounding datapath writes the program counter and the stack pointer through load ports. Program instructions set or clear the enable flag. Instruction decode and the return path are not part of this block.

Top module: `irq_entry_seq`

## Requirements
- R1: While rst_ni is low, pc_o is PC_RST (0), sp_o is SP_RST (0), ien_o is 0, and intack_o and mem_we_o are 0. The block resets into the fetch state, so fetch_o is 1 in the first cycle after reset is released. fetch_o is 0 in the cycle after that (execute).
- R2: Suppose instr_end_i is high in an execute cycle while ien_o or ist_i is 0. Then the next cycle is a fetch cycle (fetch_o = 1) and the cycle after it is execute. intack_o and mem_we_o stay 0, and pc_o, sp_o and ien_o are unchanged.
- R3: Suppose instr_end_i is high in an execute cycle while ien_o and ist_i are both 1. Then the interrupt is taken. In the first cycle after the strobe, fetch_o is 0. From the second cycle on, sp_o is one less, modulo 2^AW (0 becomes all ones).
- R4: In the second cycle after a taken strobe, mem_we_o is 1 for exactly one cycle. In that cycle mem_addr_o equals the decremented stack pointer and mem_wdata_o equals the pc_o value held at the strobe.
- R5: In the third cycle after a taken strobe, intack_o is 1 for exactly one cycle. From the fourth cycle on, pc_o equals the vector_i value present during the acknowledge cycle.
- R6: In the fifth cycle after a taken strobe, fetch_o is 1 with pc_o already equal to the vector and ien_o already 0. The sixth cycle is execute (fetch_o = 0). At most one of mem_we_o, intack_o and fetch_o is high in any cycle.
- R7: In an execute cycle, ien_clr_i clears ien_o at the next edge. Otherwise ien_set_i sets it, so clear wins when both are high. Likewise pc_ld_i loads pc_d_i and sp_ld_i loads sp_d_i at the next edge.
- R8: The take decision uses the ien_o value held before the strobe cycle. An ien_set_i arriving in the same cycle as the strobe does not cause that strobe to be taken, but ien_o is 1 afterwards.
- R9: In fetch and entry-sequence cycles, instr_end_i, pc_ld_i, sp_ld_i and ien_set_i are ignored. A sequence disturbed by them still ends with pc_o at the vector, sp_o one below its start value, ien_o at 0 and exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_end_i | input | 1 | End-of-instruction strobe from execute |
| ist_i | input | 1 | Unmasked interrupt pending status |
| ien_set_i | input | 1 | Program request to enable interrupts |
| ien_clr_i | input | 1 | Program request to disable interrupts |
| pc_ld_i | input | 1 | Datapath load of program counter |
| pc_d_i | input | AW | Program counter load value |
| sp_ld_i | input | 1 | Datapath load of stack pointer |
| sp_d_i | input | AW | Stack pointer load value |
| vector_i | input | AW | Handler vector address from the device |
| pc_o | output | AW | Program counter |
| sp_o | output | AW | Stack pointer |
| ien_o | output | 1 | Interrupt enable flag |
| intack_o | output | 1 | Interrupt acknowledge, one cycle |
| fetch_o | output | 1 | Fetch cycle indicator |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_addr_o | output | AW | Stack memory write address |
| mem_wdata_o | output | AW | Stack memory write data |

## Verification
The bench walks enable and status combinations, with stack pointers at 0 and 1 and an all-ones program counter.
- A stack that wrapped badly or that was pushed before decrementing would show up as a wrong write address.
- A gate built with OR instead of AND, or one that ignored the status input, would take an interrupt on a strobe that must fall through to fetch.
- The bench strobes while setting the enable in the same cycle. A design reading the new flag would then enter the handler one instruction early.
- The bench also drives strobes, loads and enable requests throughout a running sequence. A design that listened to them would acknowledge twice, re-enable interrupts, or leave the program counter off the vector.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_EXEC  = 3'd1,
    ST_DEC   = 3'd2,
    ST_PUSH  = 3'd3,
    ST_ACK   = 3'd4,
    ST_DIS   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       instr_end_i,
  input  logic       ien_i,
  input  logic       ist_i,
  output seq_state_e state_o,
  output logic       exec_o,
  output logic       sp_dec_o,
  output logic       push_o,
  output logic       ack_o,
  output logic       ien_drop_o,
  output logic       fetch_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC:  if (instr_end_i) state_d = (ien_i && ist_i) ? ST_DEC : ST_FETCH;
      ST_DEC:   state_d = ST_PUSH;
      ST_PUSH:  state_d = ST_ACK;
      ST_ACK:   state_d = ST_DIS;
      ST_DIS:   state_d = ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign exec_o     = (state_q == ST_EXEC);
  assign sp_dec_o   = (state_q == ST_DEC);
  assign push_o     = (state_q == ST_PUSH);
  assign ack_o      = (state_q == ST_ACK);
  assign ien_drop_o = (state_q == ST_DIS);
  assign fetch_o    = (state_q == ST_FETCH);
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] PC_RST = '0,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  logic          pc_ld_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic          sp_ld_i,
  input  logic [AW-1:0] sp_d_i,
  input  logic          ien_set_i,
  input  logic          ien_clr_i,
  input  logic          sp_dec_i,
  input  logic          vec_ld_i,
  input  logic [AW-1:0] vector_i,
  input  logic          ien_drop_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          ien_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] pc_q, sp_q;
  logic          ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= PC_RST;
    else if (vec_ld_i)          pc_q <= vector_i;
    else if (exec_i && pc_ld_i) pc_q <= pc_d_i;
  end

  // descending stack: decrement precedes the push
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= SP_RST;
    else if (sp_dec_i)          sp_q <= sp_q - ONE;
    else if (exec_i && sp_ld_i) sp_q <= sp_d_i;
  end

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ien_q <= 1'b0;
    else if (ien_drop_i)          ien_q <= 1'b0;
    else if (exec_i && ien_clr_i) ien_q <= 1'b0;
    else if (exec_i && ien_set_i) ien_q <= 1'b1;
  end

  assign pc_o  = pc_q;
  assign sp_o  = sp_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/irq_seq_memport.sv
module irq_seq_memport #(
  parameter int unsigned AW = 16
) (
  input  logic          push_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wdata_o
);
  assign we_o    = push_i;
  assign addr_o  = push_i ? sp_i : '0;
  assign wdata_o = push_i ? pc_i : '0;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] PC_RST = '0,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_end_i,
  input  logic          ist_i,
  input  logic          ien_set_i,
  input  logic          ien_clr_i,
  input  logic          pc_ld_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic          sp_ld_i,
  input  logic [AW-1:0] sp_d_i,
  input  logic [AW-1:0] vector_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          ien_o,
  output logic          intack_o,
  output logic          fetch_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o
);
  seq_state_e    state_q;
  logic          exec, sp_dec, push, ack, ien_drop;
  logic [AW-1:0] pc_q, sp_q;
  logic          ien_q;

  irq_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .instr_end_i (instr_end_i),
    .ien_i       (ien_q),
    .ist_i       (ist_i),
    .state_o     (state_q),
    .exec_o      (exec),
    .sp_dec_o    (sp_dec),
    .push_o      (push),
    .ack_o       (ack),
    .ien_drop_o  (ien_drop),
    .fetch_o     (fetch_o)
  );

  irq_seq_regs #(.AW(AW), .PC_RST(PC_RST), .SP_RST(SP_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exec_i     (exec),
    .pc_ld_i    (pc_ld_i),
    .pc_d_i     (pc_d_i),
    .sp_ld_i    (sp_ld_i),
    .sp_d_i     (sp_d_i),
    .ien_set_i  (ien_set_i),
    .ien_clr_i  (ien_clr_i),
    .sp_dec_i   (sp_dec),
    .vec_ld_i   (ack),
    .vector_i   (vector_i),
    .ien_drop_i (ien_drop),
    .pc_o       (pc_q),
    .sp_o       (sp_q),
    .ien_o      (ien_q)
  );

  irq_seq_memport #(.AW(AW)) u_mem (
    .push_i  (push),
    .sp_i    (sp_q),
    .pc_i    (pc_q),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  assign pc_o     = pc_q;
  assign sp_o     = sp_q;
  assign ien_o    = ien_q;
  assign intack_o = ack;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_end_i,
  input logic          ist_i,
  input logic [AW-1:0] vector_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o,
  input logic          ien_o,
  input logic          intack_o,
  input logic          fetch_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] mem_wdata_o,
  input seq_state_e    state_i
);
  logic in_exec;
  assign in_exec = (state_i == ST_EXEC);

  AST_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && instr_end_i && !(ien_o && ist_i)) |=> (fetch_o && !intack_o && !mem_we_o)); // R2
  AST_TAKE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && instr_end_i && ien_o && ist_i) |=> (!fetch_o && !mem_we_o && !intack_o)); // R3
  AST_TAKE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && instr_end_i && ien_o && ist_i) |=> ##1 mem_we_o); // R4
  AST_PUSH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == AW'($past(sp_o) - AW'(1)))); // R3
  AST_PUSH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == pc_o && $stable(pc_o))); // R4
  AST_PUSH_THEN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (intack_o && !mem_we_o)); // R4
  AST_ACK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intack_o |=> !intack_o); // R5
  AST_ACK_LOADS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intack_o |=> (pc_o == $past(vector_i))); // R5
  AST_ACK_THEN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intack_o |=> ##1 (fetch_o && !ien_o)); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, intack_o, fetch_o})); // R6
  AST_FETCH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o); // R6
  AST_HOLD_IN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_exec && !intack_o && !$past(intack_o) && !mem_we_o && !fetch_o) |=>
      ($stable(pc_o) || fetch_o)); // R9
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_end_i (instr_end_i),
  .ist_i       (ist_i),
  .vector_i    (vector_i),
  .pc_o        (pc_o),
  .sp_o        (sp_o),
  .ien_o       (ien_o),
  .intack_o    (intack_o),
  .fetch_o     (fetch_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .state_i     (state_q)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  localparam int unsigned AW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NCASE = 6;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] sp;
    logic [AW-1:0] vec;
    logic          ien;
    logic          ist;
  } case_t;

  localparam case_t CASES [NCASE] = '{
    '{pc: 16'd750,  sp: 16'h0100, vec: 16'h0040, ien: 1'b1, ist: 1'b1},
    '{pc: 16'd1234, sp: 16'h0200, vec: 16'h0080, ien: 1'b0, ist: 1'b1},
    '{pc: 16'h0A0A, sp: 16'h0300, vec: 16'h00C0, ien: 1'b1, ist: 1'b0},
    '{pc: 16'h0B0B, sp: 16'h0400, vec: 16'h0100, ien: 1'b0, ist: 1'b0},
    '{pc: 16'hFFFF, sp: 16'h0000, vec: 16'h0010, ien: 1'b1, ist: 1'b1},
    '{pc: 16'h0001, sp: 16'h0001, vec: 16'hFFFE, ien: 1'b1, ist: 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          instr_end_i = 1'b0, ist_i = 1'b0, ien_set_i = 1'b0, ien_clr_i = 1'b0;
  logic          pc_ld_i = 1'b0, sp_ld_i = 1'b0;
  logic [AW-1:0] pc_d_i = '0, sp_d_i = '0, vector_i = '0;
  logic [AW-1:0] pc_o, sp_o, mem_addr_o, mem_wdata_o;
  logic          ien_o, intack_o, fetch_o, mem_we_o;

  int n_chk = 0;
  int n_err = 0;

  logic          o_fetch [1:6];
  logic          o_ack   [1:6];
  logic          o_we    [1:6];
  logic          o_ien   [1:6];
  logic [AW-1:0] o_pc    [1:6];
  logic [AW-1:0] o_sp    [1:6];
  logic [AW-1:0] o_addr  [1:6];
  logic [AW-1:0] o_data  [1:6];
  int            n_ack, n_we;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_entry_seq #(.AW(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_end_i(instr_end_i), .ist_i(ist_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .pc_ld_i(pc_ld_i), .pc_d_i(pc_d_i),
    .sp_ld_i(sp_ld_i), .sp_d_i(sp_d_i), .vector_i(vector_i), .pc_o(pc_o), .sp_o(sp_o),
    .ien_o(ien_o), .intack_o(intack_o), .fetch_o(fetch_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // program state through the execute-cycle load ports
  task automatic setup(input logic [AW-1:0] pc, input logic [AW-1:0] sp, input logic ien);
    @(negedge clk_i);
    pc_ld_i = 1'b1; pc_d_i = pc; sp_ld_i = 1'b1; sp_d_i = sp;
    ien_set_i = ien; ien_clr_i = !ien;
    @(negedge clk_i);
    pc_ld_i = 1'b0; sp_ld_i = 1'b0; ien_set_i = 1'b0; ien_clr_i = 1'b0;
  endtask

  task automatic run_seq(input bit noise, input bit set_with_strobe);
    n_ack = 0; n_we = 0;
    @(negedge clk_i);
    instr_end_i = 1'b1; ien_set_i = set_with_strobe;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_i);
      if (noise && k <= 5) begin
        instr_end_i = 1'b1; pc_ld_i = 1'b1; pc_d_i = 16'hDEAD;
        sp_ld_i = 1'b1; sp_d_i = 16'h5555; ien_set_i = 1'b1;
      end else begin
        instr_end_i = 1'b0; pc_ld_i = 1'b0; sp_ld_i = 1'b0; ien_set_i = 1'b0;
      end
      o_fetch[k] = fetch_o; o_ack[k] = intack_o; o_we[k] = mem_we_o; o_ien[k] = ien_o;
      o_pc[k] = pc_o; o_sp[k] = sp_o; o_addr[k] = mem_addr_o; o_data[k] = mem_wdata_o;
      n_ack += int'(intack_o); n_we += int'(mem_we_o);
    end
  endtask

  task automatic check_take(input string tg, input case_t c);
    logic [AW-1:0] spm;
    spm = c.sp - 16'd1;
    chk({tg, " R3 no fetch after take"}, 32'(o_fetch[1]), 32'd0);
    chk({tg, " R3 sp decremented"},      32'(o_sp[2]), 32'(spm));
    chk({tg, " R4 write enable"},        32'(o_we[2]), 32'd1);
    chk({tg, " R4 write addr"},          32'(o_addr[2]), 32'(spm));
    chk({tg, " R4 write data"},          32'(o_data[2]), 32'(c.pc));
    chk({tg, " R4 one write"},           32'(n_we), 32'd1);
    chk({tg, " R5 intack cycle"},        32'(o_ack[3]), 32'd1);
    chk({tg, " R5 one intack"},          32'(n_ack), 32'd1);
    chk({tg, " R5 pc vector"},           32'(o_pc[4]), 32'(c.vec));
    chk({tg, " R6 fetch cycle"},         32'(o_fetch[5]), 32'd1);
    chk({tg, " R6 ien cleared"},         32'(o_ien[5]), 32'd0);
    chk({tg, " R6 pc at fetch"},         32'(o_pc[5]), 32'(c.vec));
    chk({tg, " R6 exec after fetch"},    32'(o_fetch[6]), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 pc reset", 32'(pc_o), 32'd0);
    chk("R1 sp reset", 32'(sp_o), 32'd0);
    chk("R1 ien reset", 32'(ien_o), 32'd0);
    chk("R1 intack reset", 32'(intack_o), 32'd0);
    chk("R1 we reset", 32'(mem_we_o), 32'd0);
    rst_ni = 1'b1;
    #1;
    chk("R1 fetch first", 32'(fetch_o), 32'd1);
    @(negedge clk_i);
    chk("R1 exec second", 32'(fetch_o), 32'd0);

    // table walk
    for (int i = 0; i < NCASE; i++) begin
      case_t c;
      c = CASES[i];
      setup(c.pc, c.sp, c.ien);
      chk("R7 pc load", 32'(pc_o), 32'(c.pc));
      chk("R7 ien load", 32'(ien_o), 32'(c.ien));
      ist_i = c.ist; vector_i = c.vec;
      run_seq(1'b0, 1'b0);
      if (c.ien && c.ist) check_take($sformatf("case%0d", i), c);
      else begin
        chk("R2 fetch next", 32'(o_fetch[1]), 32'd1);
        chk("R2 exec after", 32'(o_fetch[2]), 32'd0);
        chk("R2 no intack", 32'(n_ack), 32'd0);
        chk("R2 no write", 32'(n_we), 32'd0);
        chk("R2 pc held", 32'(o_pc[6]), 32'(c.pc));
        chk("R2 sp held", 32'(o_sp[6]), 32'(c.sp));
        chk("R2 ien held", 32'(o_ien[6]), 32'(c.ien));
      end
      ist_i = 1'b0;
    end

    // R8 enable set in the strobe cycle is not seen by that strobe
    setup(16'h0300, 16'h0050, 1'b0);
    ist_i = 1'b1; vector_i = 16'h0222;
    run_seq(1'b0, 1'b1);
    chk("R8 no take", 32'(o_fetch[1]), 32'd1);
    chk("R8 no intack", 32'(n_ack), 32'd0);
    chk("R8 ien now set", 32'(o_ien[1]), 32'd1);
    run_seq(1'b0, 1'b0);
    chk("R8 next strobe taken", 32'(n_ack), 32'd1);
    chk("R8 pc vector", 32'(o_pc[6]), 32'h0222);

    // R9 inputs driven during the sequence are ignored
    begin
      case_t c;
      c = '{pc: 16'h1357, sp: 16'h0800, vec: 16'h0444, ien: 1'b1, ist: 1'b1};
      setup(c.pc, c.sp, 1'b1);
      vector_i = c.vec;
      run_seq(1'b1, 1'b0);
      check_take("R9 noisy", c);
      chk("R9 pc final", 32'(pc_o), 32'(c.vec));
      chk("R9 sp final", 32'(sp_o), 32'h07FF);
      chk("R9 ien final", 32'(ien_o), 32'd0);
    end
    ist_i = 1'b0;

    // R7 clear wins over set
    setup(16'h0010, 16'h0020, 1'b1);
    @(negedge clk_i);
    ien_set_i = 1'b1; ien_clr_i = 1'b1;
    @(negedge clk_i);
    ien_set_i = 1'b0; ien_clr_i = 1'b0;
    chk("R7 clear wins", 32'(ien_o), 32'd0);
    @(negedge clk_i);
    ien_set_i = 1'b1;
    @(negedge clk_i);
    ien_set_i = 1'b0;
    chk("R7 set alone", 32'(ien_o), 32'd1);
    chk("R7 sp loaded", 32'(sp_o), 32'h0020);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule